// File: doc/BRIEF.md
# External Bus Chip-Select Decoder

This block turns a 20-bit byte address into four active-low chip-select strobes for devices on an external memory bus. Each strobe owns a fixed address window. Which windows apply depends on the processor mode: single-chip, memory expansion or microprocessor. A small control register enables each strobe on its own. The same register decides whether each of four shared pins acts as a general-purpose port or carries its chip select. The block also reports the width of the external data bus, which it takes from a byte-mode input pin.

The CPU reads and writes the control register through a simple address, write-enable and data port. A synchronous reset loads a default that depends on the mode: only the first select is enabled when reset happens in microprocessor mode. In single-chip mode the register has no effect on the pins. The block decodes only the normal space-mapping setting. Any other setting blocks every strobe and raises a flag.

Top module: `csel_decoder`

## Requirements
- R1: `bus_wide` is 1 (16-bit data bus) while `byte_pin` is low and 0 (8-bit data bus) while it is high.
- R2: The control register answers at byte address 0x00008. A cycle with `cfg_we` high at that address loads `cfg_wdata[3:0]` at the next rising edge. `cfg_rdata` returns the register (bits 7:4 always zero) while `cfg_addr` is 0x00008 and zero at any other address. Writes at any other address leave the register unchanged.
- R3: When `rst` is high at a rising edge, the register loads 0x01 if `proc_mode` is microprocessor (2'b10) and 0x00 otherwise.
- R4: The `proc_mode` encoding is 2'b00 single-chip, 2'b01 memory expansion, 2'b10 microprocessor and 2'b11 reserved (treated as single-chip). In single-chip and reserved modes `pin_is_cs` is 0 and `cs_n` is 4'hF, whatever the register holds.
- R5: In memory expansion and microprocessor modes, `pin_is_cs[i]` equals register bit i (1 = the pin carries chip select i, 0 = port).
- R6: In memory expansion mode with normal mapping, the windows are: select 0 at 0x30000–0xCFFFF, select 1 at 0x28000–0x2FFFF, select 2 at 0x08000–0x27FFF and select 3 at 0x04000–0x07FFF.
- R7: In microprocessor mode with normal mapping, the select-0 window runs from 0x30000 to 0xFFFFF and the other three windows match R6.
- R8: `cs_n[i]` is low exactly when all of these hold: register bit i is set, `bus_active` is high, the mode is memory expansion or microprocessor, mapping is normal, and `bus_addr` lies in window i. At most one select is low at a time.
- R9: `space_map` 2'b00 means normal mapping. Any other value drives `map_unsupported` high and holds `cs_n` at 4'hF.
- R10: Addresses outside every window, below 0x04000 or (in memory expansion mode) from 0xD0000 upward, assert no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_mode | input | 2 | Processor mode (00 single-chip, 01 memory expansion, 10 microprocessor, 11 reserved) |
| space_map | input | 2 | Space-mapping setting, 00 = normal |
| byte_pin | input | 1 | Byte-mode pin, high selects an 8-bit data bus |
| bus_active | input | 1 | An external bus cycle is in progress |
| bus_addr | input | 20 | Byte address of the external cycle |
| cfg_addr | input | 20 | Register access address |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| cs_n | output | 4 | Active-low chip selects |
| pin_is_cs | output | 4 | Per pin: 1 = chip-select function, 0 = port |
| bus_wide | output | 1 | 1 when the data bus is 16 bits wide |
| map_unsupported | output | 1 | Space-mapping setting not supported |

## Verification
The bench sweeps the address space in coarse steps and also tests both sides of every window edge. It does this for all four modes and all sixteen enable masks. A window off by one address would show up at 0x03FFF, 0x2FFFF, 0xCFFFF or 0xD0000. A mode decode that ignores microprocessor mode would miss the extended select-0 range. A design that lets the register act in single-chip or reserved mode would assert selects or claim pins that should stay ports. The bench also reset-tests under two modes, writes to a neighbouring address, writes junk into the upper register bits, drops `bus_active` and tries each unsupported mapping value. These tests catch a wrong reset default, an address decode that is too loose, and strobes that escape their gating.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int ADDR_W = 20;
    localparam int NUM_CS = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] CTRL_REG_ADDR = 20'h00008;

    typedef enum logic [1:0] {
        PM_SINGLE   = 2'b00,
        PM_MEMEXP   = 2'b01,
        PM_MICRO    = 2'b10,
        PM_RESERVED = 2'b11
    } proc_mode_e;

    typedef enum logic [1:0] {
        MAP_NORMAL = 2'b00,
        MAP_EXT1   = 2'b01,
        MAP_EXT2   = 2'b10,
        MAP_EXT3   = 2'b11
    } space_map_e;

    typedef struct packed {
        logic expand;   // external bus features usable
        logic micro;    // microprocessor-mode windows
        logic map_ok;   // mapping decodable
    } mode_info_t;

    // Lower bound of a select window (same in every supported mode).
    function automatic logic [ADDR_W-1:0] win_lo(input int idx);
        case (idx)
            0:       return 20'h30000;
            1:       return 20'h28000;
            2:       return 20'h08000;
            default: return 20'h04000;
        endcase
    endfunction

    // Upper bound of a select window; only select 0 grows in micro mode.
    function automatic logic [ADDR_W-1:0] win_hi(input int idx, input bit micro);
        case (idx)
            0:       return micro ? 20'hFFFFF : 20'hCFFFF;
            1:       return 20'h2FFFF;
            2:       return 20'h27FFF;
            default: return 20'h07FFF;
        endcase
    endfunction

    function automatic mode_info_t decode_mode(input proc_mode_e m, input space_map_e s);
        mode_info_t r;
        r.expand = (m == PM_MEMEXP) || (m == PM_MICRO);
        r.micro  = (m == PM_MICRO);
        r.map_ok = (s == MAP_NORMAL);
        return r;
    endfunction

endpackage

// File: rtl/csdec_ctrl_reg.sv
module csdec_ctrl_reg
    import csdec_pkg::*;
#(
    parameter int                 N_SEL    = NUM_CS,
    parameter int                 AW       = ADDR_W,
    parameter int                 DW       = DATA_W,
    parameter logic [AW-1:0]      REG_ADDR = CTRL_REG_ADDR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             micro_mode,
    input  logic [AW-1:0]    cfg_addr,
    input  logic             cfg_we,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [N_SEL-1:0] ctrl_q,
    output logic [DW-1:0]    cfg_rdata
);

    localparam logic [N_SEL-1:0] RST_MICRO = N_SEL'(1);
    localparam logic [N_SEL-1:0] RST_OTHER = '0;

    logic hit;

    assign hit = (cfg_addr == REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= micro_mode ? RST_MICRO : RST_OTHER;
        end else if (cfg_we && hit) begin
            ctrl_q <= cfg_wdata[N_SEL-1:0];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            cfg_rdata[N_SEL-1:0] = ctrl_q;
        end
    end

endmodule

// File: rtl/csdec_window.sv
module csdec_window
    import csdec_pkg::*;
#(
    parameter int            AW       = ADDR_W,
    parameter logic [AW-1:0] LO       = '0,
    parameter logic [AW-1:0] HI_NORM  = '1,
    parameter logic [AW-1:0] HI_MICRO = '1
) (
    input  logic [AW-1:0] addr,
    input  logic          micro,
    output logic          hit
);

    logic [AW-1:0] hi_bound;

    assign hi_bound = micro ? HI_MICRO : HI_NORM;
    assign hit      = (addr >= LO) && (addr <= hi_bound);

endmodule

// File: rtl/csdec_pin_mux.sv
module csdec_pin_mux
    import csdec_pkg::*;
#(
    parameter int N_SEL = NUM_CS
) (
    input  mode_info_t       info,
    input  logic [N_SEL-1:0] ctrl_q,
    input  logic [N_SEL-1:0] win_hit,
    input  logic             bus_active,
    output logic [N_SEL-1:0] pin_is_cs,
    output logic [N_SEL-1:0] cs_n
);

    assign pin_is_cs = info.expand ? ctrl_q : '0;

    for (genvar i = 0; i < N_SEL; i++) begin : g_sel
        assign cs_n[i] = ~(pin_is_cs[i] & bus_active & info.map_ok & win_hit[i]);
    end

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
    import csdec_pkg::*;
#(
    parameter int N_SEL = NUM_CS,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       proc_mode,
    input  logic [1:0]       space_map,
    input  logic             byte_pin,
    input  logic             bus_active,
    input  logic [AW-1:0]    bus_addr,
    input  logic [AW-1:0]    cfg_addr,
    input  logic             cfg_we,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    output logic [N_SEL-1:0] cs_n,
    output logic [N_SEL-1:0] pin_is_cs,
    output logic             bus_wide,
    output logic             map_unsupported
);

    mode_info_t       info;
    logic [N_SEL-1:0] ctrl_q;
    logic [N_SEL-1:0] win_hit;

    assign info            = decode_mode(proc_mode_e'(proc_mode), space_map_e'(space_map));
    assign bus_wide        = ~byte_pin;
    assign map_unsupported = ~info.map_ok;

    csdec_ctrl_reg #(
        .N_SEL(N_SEL), .AW(AW), .DW(DW), .REG_ADDR(CTRL_REG_ADDR)
    ) u_reg (
        .clk        (clk),
        .rst        (rst),
        .micro_mode (info.micro),
        .cfg_addr   (cfg_addr),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .ctrl_q     (ctrl_q),
        .cfg_rdata  (cfg_rdata)
    );

    for (genvar i = 0; i < N_SEL; i++) begin : g_win
        csdec_window #(
            .AW       (AW),
            .LO       (win_lo(i)),
            .HI_NORM  (win_hi(i, 1'b0)),
            .HI_MICRO (win_hi(i, 1'b1))
        ) u_win (
            .addr  (bus_addr),
            .micro (info.micro),
            .hit   (win_hit[i])
        );
    end

    csdec_pin_mux #(.N_SEL(N_SEL)) u_mux (
        .info       (info),
        .ctrl_q     (ctrl_q),
        .win_hit    (win_hit),
        .bus_active (bus_active),
        .pin_is_cs  (pin_is_cs),
        .cs_n       (cs_n)
    );

endmodule

// File: rtl/csdec_checker.sv
module csdec_checker (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  proc_mode,
    input logic [1:0]  space_map,
    input logic        byte_pin,
    input logic        bus_active,
    input logic [19:0] cfg_addr,
    input logic        cfg_we,
    input logic [7:0]  cfg_wdata,
    input logic [7:0]  cfg_rdata,
    input logic [3:0]  cs_n,
    input logic [3:0]  pin_is_cs,
    input logic        bus_wide,
    input logic        map_unsupported,
    input logic [3:0]  ctrl_q
);

    p_width_r1: assert property (@(posedge clk) disable iff (rst)
        bus_wide == ~byte_pin);

    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 20'h00008) |=> ctrl_q == $past(cfg_wdata[3:0]));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[7:4] == 4'h0);

    p_single_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (proc_mode == 2'b00 || proc_mode == 2'b11) |-> (cs_n == 4'hF && pin_is_cs == 4'h0));

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    p_idle_bus_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_active |-> cs_n == 4'hF);

    p_gated_by_pin_r8: assert property (@(posedge clk) disable iff (rst)
        ((~cs_n) & ~pin_is_cs) == 4'h0);

    p_unsupported_r9: assert property (@(posedge clk) disable iff (rst)
        (space_map != 2'b00) |-> (map_unsupported && cs_n == 4'hF));

endmodule

bind csel_decoder csdec_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .proc_mode       (proc_mode),
    .space_map       (space_map),
    .byte_pin        (byte_pin),
    .bus_active      (bus_active),
    .cfg_addr        (cfg_addr),
    .cfg_we          (cfg_we),
    .cfg_wdata       (cfg_wdata),
    .cfg_rdata       (cfg_rdata),
    .cs_n            (cs_n),
    .pin_is_cs       (pin_is_cs),
    .bus_wide        (bus_wide),
    .map_unsupported (map_unsupported),
    .ctrl_q          (ctrl_q)
);

// File: tb/csel_decoder_test.sv
module csel_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  proc_mode = 2'b10;
    logic [1:0]  space_map = 2'b00;
    logic        byte_pin = 1'b0;
    logic        bus_active = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [19:0] cfg_addr = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  cs_n;
    logic [3:0]  pin_is_cs;
    logic        bus_wide;
    logic        map_unsupported;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    csel_decoder uut (
        .clk(clk), .rst(rst), .proc_mode(proc_mode), .space_map(space_map),
        .byte_pin(byte_pin), .bus_active(bus_active), .bus_addr(bus_addr),
        .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cs_n(cs_n), .pin_is_cs(pin_is_cs),
        .bus_wide(bus_wide), .map_unsupported(map_unsupported)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 20'h00008;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        proc_mode = m; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Expected selects from the window table of the requirements.
    function automatic logic [3:0] exp_cs_n(input int m, input int map, input logic [3:0] mask,
                                            input logic act, input int a);
        logic [3:0] sel = 4'h0;
        if ((m == 1 || m == 2) && map == 0 && act) begin
            if (a >= 'h30000 && a <= (m == 2 ? 'hFFFFF : 'hCFFFF)) sel[0] = 1'b1;
            if (a >= 'h28000 && a <= 'h2FFFF) sel[1] = 1'b1;
            if (a >= 'h08000 && a <= 'h27FFF) sel[2] = 1'b1;
            if (a >= 'h04000 && a <= 'h07FFF) sel[3] = 1'b1;
        end
        return ~(sel & mask);
    endfunction

    function automatic int edge_addr(input int k);
        case (k)
            0: return 'h00000;  1: return 'h03FFF;  2: return 'h04000;
            3: return 'h07FFF;  4: return 'h08000;  5: return 'h27FFF;
            6: return 'h28000;  7: return 'h2FFFF;  8: return 'h30000;
            9: return 'hCFFFF; 10: return 'hD0000; default: return 'hFFFFF;
        endcase
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        cfg_addr = 20'h00008;
        // R3: reset in microprocessor mode
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R3 micro reset value", cfg_rdata, 8'h01);
        check("R5 micro reset pin function", pin_is_cs, 4'h1);
        // R3: reset in memory expansion mode
        do_reset(2'b01);
        #1;
        check("R3 memexp reset value", cfg_rdata, 8'h00);
        check("R5 memexp reset pins", pin_is_cs, 4'h0);

        // R1: width flag
        byte_pin = 1'b1; #1; check("R1 byte pin high", bus_wide, 1'b0);
        byte_pin = 1'b0; #1; check("R1 byte pin low", bus_wide, 1'b1);

        // R2: write, upper bits, other addresses
        reg_write(20'h00008, 8'hF5);
        #1; check("R2 write upper bits dropped", cfg_rdata, 8'h05);
        reg_write(20'h00009, 8'h0A);
        #1; check("R2 write elsewhere ignored", cfg_rdata, 8'h05);
        cfg_addr = 20'h00010; #1;
        check("R2 read elsewhere is zero", cfg_rdata, 8'h00);
        cfg_addr = 20'h00008;

        // R4..R8, R10: sweep modes, masks, addresses
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            proc_mode = 2'(m);
            for (int mask = 0; mask < 16; mask++) begin
                reg_write(20'h00008, 8'(mask) | 8'hA0);
                #1;
                check("R2 readback", cfg_rdata, 8'(mask));
                check((m == 0 || m == 3) ? "R4 pins forced to port" : "R5 pin function",
                      pin_is_cs, (m == 1 || m == 2) ? 4'(mask) : 4'h0);
                bus_active = 1'b1;
                for (int k = 0; k < 512 + 12; k++) begin
                    int a;
                    a = (k < 512) ? (k * 'h800 + (k % 5) * 'h1FF) : edge_addr(k - 512);
                    bus_addr = 20'(a);
                    #1;
                    check(m == 2 ? "R7 micro windows" :
                          (m == 1 ? "R6 memexp windows R10" : "R4 single-chip idle"),
                          cs_n, exp_cs_n(m, 0, 4'(mask), 1'b1, a));
                end
                // R8: no bus cycle
                bus_active = 1'b0;
                bus_addr = 20'h30000;
                #1;
                check("R8 idle bus", cs_n, 4'hF);
            end
        end

        // R9: unsupported mapping
        @(negedge clk);
        proc_mode = 2'b10;
        reg_write(20'h00008, 8'h0F);
        bus_active = 1'b1;
        for (int s = 0; s < 4; s++) begin
            space_map = 2'(s);
            for (int k = 0; k < 12; k++) begin
                bus_addr = 20'(edge_addr(k));
                #1;
                check("R9 mapping gate", {28'h0, map_unsupported, cs_n},
                      {28'h0, (s != 0), exp_cs_n(2, s, 4'hF, 1'b1, edge_addr(k))});
            end
        end
        space_map = 2'b00;
        bus_active = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule